// File: doc/BRIEF.md
# Accumulator Arithmetic and Compare Unit

This block is the 8-bit arithmetic and logic datapath of an accumulator machine that has no flag register. The accumulator is always the left operand and always takes the result. One operation class picks a group of operations, and a 3-bit code picks the operation inside that group:

- The single-operand group works on the accumulator alone.
- The two-operand group combines the accumulator with one general register value.
- The compare class writes the unsigned less-than result, 0 or 1, back into the accumulator.

Software finds a carry this way. After `acc = acc + x`, the test `acc < x` yields the carry bit.

Operands enter on a valid/ready stream and results leave on a second valid/ready stream, with one register stage between them. An input item is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or its result is being taken in the same cycle. A result stays on `out_acc` and `out_valid` stays high until the consumer raises `out_ready`, so back-pressure passes straight to the input side. Results leave in the order their operands were accepted, one result per accepted item.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid` is 0 and `in_ready` is 1.
- R2: An item accepted on an edge gives `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_acc` does not change.
- R3: Class 0 (single-operand) codes 0 to 7 give, in order: zero, shift left by one, logical shift right by one, arithmetic shift right by one, increment, decrement, bitwise complement, two's-complement negate.
- R4: Increment, decrement and negate wrap modulo 256. For example, 0xFF+1 gives 0x00, 0x00-1 gives 0xFF, and negating 0x80 gives 0x80.
- R5: Class 1 (two-operand) codes 0 to 4 give acc+reg and acc-reg, both modulo 256, then AND, OR and XOR.
- R6: Class 1 codes 5, 6 and 7 shift the accumulator left logically, right logically and right arithmetically. The shift amount is the full 8-bit register value. An amount of 8 or more gives 0x00 for the logical shifts and eight copies of accumulator bit 7 for the arithmetic shift.
- R7: Class 2 (compare) gives 0x01 when acc < reg as unsigned numbers, and 0x00 otherwise. This includes the case acc == reg. The code is ignored.
- R8: Class 3 returns the accumulator unchanged, whatever the code and register value are.
- R9: Results come out in acceptance order, exactly one for each accepted item, and never when nothing was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand item present |
| in_ready | output | 1 | Block can take an item this cycle |
| in_acc | input | 8 | Current accumulator value (left operand) |
| in_reg | input | 8 | Selected general register value |
| in_cls | input | 2 | Operation class: 0 single, 1 two-operand, 2 compare, 3 pass |
| in_op | input | 3 | Operation code within the class |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_acc | output | 8 | New accumulator value |

## Verification
There is only one piece of internal state, the output register with its valid bit. If that state goes wrong, the fault shows at the ports one edge after the accepting transfer. It can appear as a wrong `out_acc`, as a result that is lost or repeated, or as a result that changes while the consumer is stalling.

The scoreboard compares every result, in order, against a model written from the requirements. Consumer stalls are mixed in so that hold and ordering faults come out as mismatches or as an unexpected `out_valid`. The corner cases are chosen to expose a swapped operation code or a wrong class decode at the first affected result:

- shift amounts of 0, 7, 8 and 200;
- wrap at 0x00, 0x7F, 0x80 and 0xFF;
- compares of equal operands.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [1:0] {
    CLS_UNARY  = 2'd0,
    CLS_BINARY = 2'd1,
    CLS_CMP    = 2'd2,
    CLS_PASS   = 2'd3
  } acc_cls_e;

  typedef enum logic [2:0] {
    U_ZERO = 3'd0, U_SHL1 = 3'd1, U_SHR1 = 3'd2, U_SAR1 = 3'd3,
    U_INC  = 3'd4, U_DEC  = 3'd5, U_NOT  = 3'd6, U_NEG  = 3'd7
  } unary_op_e;

  typedef enum logic [2:0] {
    B_ADD = 3'd0, B_SUB = 3'd1, B_AND = 3'd2, B_OR  = 3'd3,
    B_XOR = 3'd4, B_SHL = 3'd5, B_SHR = 3'd6, B_SAR = 3'd7
  } binary_op_e;
endpackage

// File: rtl/acc_unary_unit.sv
module acc_unary_unit #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] acc,
  input  logic [2:0]    op,
  output logic [DW-1:0] res
);
  import acc_alu_pkg::*;

  always_comb begin
    unique case (unary_op_e'(op))
      U_ZERO:  res = '0;
      U_SHL1:  res = {acc[DW-2:0], 1'b0};
      U_SHR1:  res = {1'b0, acc[DW-1:1]};
      U_SAR1:  res = {acc[DW-1], acc[DW-1:1]};
      U_INC:   res = acc + DW'(1);
      U_DEC:   res = acc - DW'(1);
      U_NOT:   res = ~acc;
      default: res = DW'(0) - acc;
    endcase
  end
endmodule

// File: rtl/acc_binary_unit.sv
module acc_binary_unit #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] rv,
  input  logic [2:0]    op,
  output logic [DW-1:0] res
);
  import acc_alu_pkg::*;

  localparam int SW = $clog2(DW);

  logic [SW-1:0] amt;
  logic          over;
  logic [DW-1:0] shl_v, shr_v, sar_v;

  assign amt  = rv[SW-1:0];
  assign over = |rv[DW-1:SW];

  always_comb begin
    shl_v = over ? '0 : (acc << amt);
    shr_v = over ? '0 : (acc >> amt);
    sar_v = over ? {DW{acc[DW-1]}} : DW'($signed(acc) >>> amt);
  end

  always_comb begin
    unique case (binary_op_e'(op))
      B_ADD:   res = acc + rv;
      B_SUB:   res = acc - rv;
      B_AND:   res = acc & rv;
      B_OR:    res = acc | rv;
      B_XOR:   res = acc ^ rv;
      B_SHL:   res = shl_v;
      B_SHR:   res = shr_v;
      default: res = sar_v;
    endcase
  end
endmodule

// File: rtl/acc_compare_unit.sv
module acc_compare_unit #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] rv,
  output logic [DW-1:0] res
);
  logic [DW:0] diff;

  // The borrow out of acc - rv is the unsigned less-than result.
  assign diff = {1'b0, acc} - {1'b0, rv};
  assign res  = {{(DW-1){1'b0}}, diff[DW]};
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_acc,
  input  logic [DW-1:0] in_reg,
  input  logic [1:0]    in_cls,
  input  logic [2:0]    in_op,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_acc
);
  import acc_alu_pkg::*;

  logic [DW-1:0] un_res, bi_res, cmp_res, nxt;

  acc_unary_unit #(.DW(DW)) u_unary (
    .acc (in_acc),
    .op  (in_op),
    .res (un_res)
  );

  acc_binary_unit #(.DW(DW)) u_binary (
    .acc (in_acc),
    .rv  (in_reg),
    .op  (in_op),
    .res (bi_res)
  );

  acc_compare_unit #(.DW(DW)) u_cmp (
    .acc (in_acc),
    .rv  (in_reg),
    .res (cmp_res)
  );

  always_comb begin
    unique case (acc_cls_e'(in_cls))
      CLS_UNARY:  nxt = un_res;
      CLS_BINARY: nxt = bi_res;
      CLS_CMP:    nxt = cmp_res;
      default:    nxt = in_acc;
    endcase
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_acc   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_acc <= nxt;
    end
  end
endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [DW-1:0] in_acc,
  input logic [DW-1:0] in_reg,
  input logic [1:0]    in_cls,
  input logic [2:0]    in_op,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_acc
);
  logic take;
  assign take = in_valid && in_ready;

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_acc)));

  p_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_cls == 2'd0 && in_op == 3'd0) |=> (out_acc == '0));

  p_xor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_cls == 2'd1 && in_op == 3'd4) |=> (out_acc == $past(in_acc ^ in_reg)));

  p_bool_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_cls == 2'd2) |=> (out_acc[DW-1:1] == '0));

  p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_cls == 2'd3) |=> (out_acc == $past(in_acc)));

  p_nothing_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_ready) |=> !out_valid);
endmodule

bind acc_alu acc_alu_checker #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_acc    (in_acc),
  .in_reg    (in_reg),
  .in_cls    (in_cls),
  .in_op     (in_op),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_acc   (out_acc)
);

// File: tb/acc_alu_bench.sv
`timescale 1ns/1ps
module acc_alu_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_acc = '0;
  logic [7:0] in_reg = '0;
  logic [1:0] in_cls = '0;
  logic [2:0] in_op = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_acc;

  int n_tests = 0;
  int n_fail  = 0;
  bit stall_mode = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  acc_alu u_acc_alu (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_acc(in_acc), .in_reg(in_reg), .in_cls(in_cls), .in_op(in_op),
    .out_valid(out_valid), .out_ready(out_ready), .out_acc(out_acc)
  );

  function automatic logic [7:0] model(input logic [1:0] c, input logic [2:0] o,
                                       input logic [7:0] a, input logic [7:0] r);
    logic [7:0] v;
    v = a;
    if (c == 2'd0) begin
      case (o)
        3'd0: v = 8'h00;
        3'd1: v = {a[6:0], 1'b0};
        3'd2: v = {1'b0, a[7:1]};
        3'd3: v = {a[7], a[7:1]};
        3'd4: v = a + 8'd1;
        3'd5: v = a - 8'd1;
        3'd6: v = ~a;
        default: v = 8'd0 - a;
      endcase
    end else if (c == 2'd1) begin
      case (o)
        3'd0: v = a + r;
        3'd1: v = a - r;
        3'd2: v = a & r;
        3'd3: v = a | r;
        3'd4: v = a ^ r;
        3'd5: begin v = a; for (int k = 0; k < 8; k++) if (k < r) v = {v[6:0], 1'b0}; end
        3'd6: begin v = a; for (int k = 0; k < 8; k++) if (k < r) v = {1'b0, v[7:1]}; end
        default: begin v = a; for (int k = 0; k < 8; k++) if (k < r) v = {v[7], v[7:1]}; end
      endcase
    end else if (c == 2'd2) begin
      v = (a < r) ? 8'd1 : 8'd0;
    end
    return v;
  endfunction

  function automatic string tag_of(input logic [1:0] c, input logic [2:0] o);
    if (c == 2'd0) return (o >= 3'd4 && o != 3'd6) ? "R4" : "R3";
    if (c == 2'd1) return (o >= 3'd5) ? "R6" : "R5";
    if (c == 2'd2) return "R7";
    return "R8";
  endfunction

  task automatic send(input logic [1:0] c, input logic [2:0] o,
                      input logic [7:0] a, input logic [7:0] r);
    exp_t e;
    bit   took;
    took = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_cls = c; in_op = o; in_acc = a; in_reg = r;
    while (!took) begin
      #1;
      if (in_ready) begin
        e.val = model(c, o, a, r);
        e.tag = tag_of(c, o);
        sb.push_back(e);
        took = 1'b1;
      end else begin
        @(negedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: drive out_ready at each negedge, sample 1 ns later.
  initial begin
    logic [7:0] lfsr;
    logic [7:0] held;
    bit         holding;
    exp_t       e;
    lfsr = 8'h5B;
    holding = 1'b0;
    held = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        out_ready = 1'b0;
      end else begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready = stall_mode ? lfsr[0] : 1'b1;
        #1;
        if (holding) begin
          n_tests++;
          if (!out_valid || out_acc != held) begin
            n_fail++;
            $display("FAIL R2 hold: valid=%0b acc=%h expected valid=1 acc=%h", out_valid, out_acc, held);
          end
        end
        holding = out_valid && !out_ready;
        held = out_acc;
        if (out_valid && out_ready) begin
          n_tests++;
          if (sb.size() == 0) begin
            n_fail++;
            $display("FAIL R9 result %h with nothing expected", out_acc);
          end else begin
            e = sb.pop_front();
            if (out_acc != e.val) begin
              n_fail++;
              $display("FAIL %s (R9 order): got %h expected %h", e.tag, out_acc, e.val);
            end
          end
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] ra, rb;
    logic [7:0] sum;
    repeat (3) @(negedge clk);
    #1;
    n_tests++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 in reset: valid=%b ready=%b expected 0 1", out_valid, in_ready);
    end
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    n_tests++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 after reset: valid=%b ready=%b expected 0 1", out_valid, in_ready);
    end

    // R3 / R4: every single-operand code on edge values
    foreach (ra[i]) ; // no-op for tool friendliness
    for (int o = 0; o < 8; o++) begin
      send(2'd0, 3'(o), 8'h00, 8'h00);
      send(2'd0, 3'(o), 8'h80, 8'h11);
      send(2'd0, 3'(o), 8'hFF, 8'h22);
      send(2'd0, 3'(o), 8'h7F, 8'h33);
    end
    // R5: arithmetic and logic, including wrap
    send(2'd1, 3'd0, 8'hF0, 8'h20);
    send(2'd1, 3'd1, 8'h05, 8'h09);
    send(2'd1, 3'd1, 8'h09, 8'h05);
    send(2'd1, 3'd2, 8'hCA, 8'h5F);
    send(2'd1, 3'd3, 8'hCA, 8'h15);
    send(2'd1, 3'd4, 8'hCA, 8'hFF);
    // R6: shift amounts including 8 and above
    for (int o = 5; o < 8; o++) begin
      send(2'd1, 3'(o), 8'h96, 8'd0);
      send(2'd1, 3'(o), 8'h96, 8'd1);
      send(2'd1, 3'(o), 8'h96, 8'd7);
      send(2'd1, 3'(o), 8'h96, 8'd8);
      send(2'd1, 3'(o), 8'h96, 8'd200);
      send(2'd1, 3'(o), 8'h6B, 8'd9);
    end
    // R7: unsigned compare, code ignored, and carry recovery
    send(2'd2, 3'd0, 8'h10, 8'h20);
    send(2'd2, 3'd5, 8'h20, 8'h20);
    send(2'd2, 3'd7, 8'hFF, 8'h00);
    send(2'd2, 3'd2, 8'h00, 8'hFF);
    sum = 8'hF0 + 8'h20;
    send(2'd2, 3'd0, sum, 8'h20);
    // R8: pass class ignores code and register
    send(2'd3, 3'd0, 8'hA5, 8'h00);
    send(2'd3, 3'd7, 8'h3C, 8'hFF);

    // R2 / R9: back-pressure with pseudo-random operands
    stall_mode = 1'b1;
    ra = 8'h1D; rb = 8'hC3;
    for (int n = 0; n < 120; n++) begin
      ra = {ra[6:0], ra[7] ^ ra[5] ^ ra[4] ^ ra[3]};
      rb = rb + 8'h3B;
      send(2'(n % 4), 3'(n / 4), ra, (n % 3 == 0) ? (rb & 8'h0F) : rb);
    end
    stall_mode = 1'b0;
    repeat (10) @(negedge clk);
    n_tests++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R9 missing results: got %0d pending expected 0", sb.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule